// File: doc/BRIEF.md
# Collision, SQE Test and Jabber Controller

This block holds the control logic between the attachment unit interface of a fiber transceiver and its optical transmit and receive paths. It watches transmit activity on the DO pair and receive activity from the optical receiver. From these it decides whether a collision is present and which data stream is sent back to the station on the DI pair. It also gates a collision square wave for the CI pair. All inputs are sampled on one fast system clock, and every time interval is a parameter counted in clock cycles.

The collision square wave has three sources. The first is a real collision, where transmit and receive are active together while loopback is enabled. The second is a timed SQE test burst in the gap after each transmission. The third is the jabber state, which starts after an over-long transmission. Jabber also turns the transmitter off, and the block releases it only after a long unbroken stretch of transmit idle. Three retriggerable stretchers drive the transmit, receive and collision indicators. A plain level drives the jabber indicator. All indicator outputs are active low.

Top module: `ci_collision_ctrl`

## Requirements
- R1: When tx_act and rx_act are both high at a clock edge and lb_off is low, col_osc_en is high after that edge. The collision source drops after the first edge at which either tx_act or rx_act is low.
- R2: While lb_off is high, no collision is flagged. In that case di_data follows rx_data whatever the values of tx_act and rx_act.
- R3: With lb_off low, di_data equals tx_data when tx_act is high and rx_act is low. In every other case, including a collision, di_data equals rx_data.
- R4: While col_osc_en is low, col_wave_p and col_wave_n are both 0. When col_osc_en rises, the outputs start with col_wave_p=0 and col_wave_n=1. They then swap every OSC_HALF_CYC cycles and always stay complementary.
- R5: Take E0 as the first edge that samples tx_act low after it was high, with sqe_en=1, link_ok=1 and no jabber. The SQE burst then holds col_osc_en high from edge E0+SQE_DELAY_CYC for SQE_LEN_CYC cycles.
- R6: No SQE burst follows a transmission when sqe_en is 0 or link_ok is 0.
- R7: If tx_act goes high during the SQE wait or the burst, the test is cancelled and col_osc_en drops after the next edge.
- R8: After tx_act has been high for JAB_LIMIT_CYC consecutive edges, tx_enable goes to 0 and led_jab_n goes to 0, and col_osc_en is held high. A shorter transmission leaves tx_enable at 1.
- R9: Jabber ends only after UNJAB_IDLE_CYC consecutive edges with tx_act low. Any transmit activity restarts that count. A transmission that ends during jabber is not followed by an SQE burst.
- R10: Each of led_tx_n, led_rx_n and led_col_n goes low after an edge that samples its event high, and stays low for LED_ON_CYC cycles after the last such edge. A new event restarts the interval. The events are tx_act, rx_act and a flagged collision.
- R11: After reset all indicator outputs are 1, tx_enable is 1, col_osc_en is 0 and both wave outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the collision wave |
| rst | input | 1 | Synchronous active-high reset |
| tx_act | input | 1 | Transmit pair carries valid data |
| rx_act | input | 1 | Optical receive path carries valid data |
| tx_data | input | 1 | Sliced transmit data from the DO pair |
| rx_data | input | 1 | Sliced optical receive data |
| link_ok | input | 1 | Link is in pass state (not low light) |
| lb_off | input | 1 | Loopback disable strap (full duplex, no collision) |
| sqe_en | input | 1 | SQE test enable strap |
| col_osc_en | output | 1 | Collision oscillator enable |
| col_wave_p | output | 1 | Collision square wave, true side |
| col_wave_n | output | 1 | Collision square wave, complement side |
| di_data | output | 1 | Data sent to the DI pair |
| tx_enable | output | 1 | Optical transmitter data enable (low in jabber) |
| led_tx_n | output | 1 | Stretched transmit indicator, active low |
| led_rx_n | output | 1 | Stretched receive indicator, active low |
| led_col_n | output | 1 | Stretched collision indicator, active low |
| led_jab_n | output | 1 | Jabber indicator, active low |

## Verification
A flagged collision that is wrong shows on col_osc_en one edge after the inputs change. A wrong loopback selection shows on di_data in the same cycle. A stuck or mis-timed SQE sequencer shows as col_osc_en rising a cycle early or late in the gap after transmit. It can also appear as a burst that was never cancelled or should never have started. A jabber counter that is off by one moves the fall of tx_enable, or its return, by exactly one cycle at the limit edge. The bench therefore samples right at those boundary edges rather than somewhere inside the windows.

// File: rtl/ci_ctrl_pkg.sv
package ci_ctrl_pkg;

    typedef enum logic [1:0] {
        SQE_IDLE  = 2'd0,
        SQE_WAIT  = 2'd1,
        SQE_BURST = 2'd2
    } sqe_state_e;

    // sources feeding the shared collision oscillator
    typedef struct packed {
        logic col;
        logic sqe;
        logic jab;
    } osc_src_t;

    localparam int LED_COUNT = 3;
    localparam int LED_TX    = 0;
    localparam int LED_RX    = 1;
    localparam int LED_COL   = 2;

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ci_square_osc.sv
module ci_square_osc
    import ci_ctrl_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic wave_p,
    output logic wave_n
);
    localparam int W = cnt_bits(HALF_CYC);
    localparam logic [W-1:0] HALF_LAST = W'(HALF_CYC - 1);

    logic [W-1:0] cnt;
    logic         ph;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (cnt == HALF_LAST) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wave_p = en & ph;
    assign wave_n = en & ~ph;

    // R4
    osc_start_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (!wave_p && wave_n));

    // R4
    osc_complement_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (wave_p != wave_n));

endmodule

// File: rtl/ci_sqe_timer.sv
module ci_sqe_timer
    import ci_ctrl_pkg::*;
#(
    parameter int DELAY_CYC = 40,
    parameter int LEN_CYC   = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_act,
    input  logic sqe_en,
    input  logic link_ok,
    input  logic jab,
    output logic burst
);
    localparam int CW = cnt_bits(max2(DELAY_CYC, LEN_CYC));
    localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] LEN_LAST   = CW'(LEN_CYC - 1);

    sqe_state_e    state;
    logic [CW-1:0] cnt;
    logic          tx_prev;
    logic          tx_end;

    assign tx_end = tx_prev & ~tx_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQE_IDLE;
            cnt     <= '0;
            tx_prev <= 1'b0;
        end else begin
            tx_prev <= tx_act;
            case (state)
                SQE_IDLE: begin
                    cnt <= '0;
                    if (tx_end && sqe_en && link_ok && !jab)
                        state <= SQE_WAIT;
                end
                SQE_WAIT: begin
                    if (tx_act) begin
                        state <= SQE_IDLE;
                        cnt   <= '0;
                    end else if (cnt == DELAY_LAST) begin
                        state <= SQE_BURST;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQE_BURST: begin
                    if (tx_act || cnt == LEN_LAST) begin
                        state <= SQE_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SQE_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign burst = (state == SQE_BURST);

    // R5
    sqe_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(burst) |-> !tx_act);

    // R7
    sqe_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (burst && tx_act) |=> !burst);

endmodule

// File: rtl/ci_jabber.sv
module ci_jabber
    import ci_ctrl_pkg::*;
#(
    parameter int LIMIT_CYC = 2000,
    parameter int UNJAB_CYC = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_act,
    output logic jab
);
    localparam int RW = cnt_bits(LIMIT_CYC);
    localparam int IW = cnt_bits(UNJAB_CYC);
    localparam logic [RW-1:0] RUN_LAST  = RW'(LIMIT_CYC - 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(UNJAB_CYC - 1);

    logic [RW-1:0] run_cnt;
    logic [IW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            jab      <= 1'b0;
            run_cnt  <= '0;
            idle_cnt <= '0;
        end else if (!jab) begin
            idle_cnt <= '0;
            if (!tx_act) begin
                run_cnt <= '0;
            end else if (run_cnt == RUN_LAST) begin
                run_cnt <= '0;
                jab     <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
            if (tx_act) begin
                idle_cnt <= '0;
            end else if (idle_cnt == IDLE_LAST) begin
                idle_cnt <= '0;
                jab      <= 1'b0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    // R8
    jab_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(jab) |-> $past(tx_act));

    // R9
    jab_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(jab) |-> !$past(tx_act));

endmodule

// File: rtl/ci_led_stretch.sv
module ci_led_stretch
    import ci_ctrl_pkg::*;
#(
    parameter int ON_CYC = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic event_in,
    output logic led_n
);
    localparam int W = cnt_bits(ON_CYC);
    localparam logic [W-1:0] ON_LOAD = W'(ON_CYC);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (event_in)
            cnt <= ON_LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign led_n = (cnt == '0);

    // R10
    led_lit_chk: assert property (@(posedge clk) disable iff (rst)
        event_in |=> !led_n);

endmodule

// File: rtl/ci_collision_ctrl.sv
module ci_collision_ctrl
    import ci_ctrl_pkg::*;
#(
    parameter int OSC_HALF_CYC   = 2,
    parameter int SQE_DELAY_CYC  = 40,
    parameter int SQE_LEN_CYC    = 40,
    parameter int JAB_LIMIT_CYC  = 2000,
    parameter int UNJAB_IDLE_CYC = 4000,
    parameter int LED_ON_CYC     = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_act,
    input  logic rx_act,
    input  logic tx_data,
    input  logic rx_data,
    input  logic link_ok,
    input  logic lb_off,
    input  logic sqe_en,
    output logic col_osc_en,
    output logic col_wave_p,
    output logic col_wave_n,
    output logic di_data,
    output logic tx_enable,
    output logic led_tx_n,
    output logic led_rx_n,
    output logic led_col_n,
    output logic led_jab_n
);
    osc_src_t             src;
    logic                 col_q;
    logic                 sqe_burst;
    logic                 jab;
    logic [LED_COUNT-1:0] led_evt;
    logic [LED_COUNT-1:0] led_n_vec;

    // collision flag: both directions busy with loopback in use
    always_ff @(posedge clk) begin
        if (rst)
            col_q <= 1'b0;
        else
            col_q <= tx_act & rx_act & ~lb_off;
    end

    // loopback select: DO echoes only while transmitting alone
    assign di_data = (tx_act & ~rx_act & ~lb_off) ? tx_data : rx_data;

    ci_sqe_timer #(
        .DELAY_CYC (SQE_DELAY_CYC),
        .LEN_CYC   (SQE_LEN_CYC)
    ) u_sqe (
        .clk     (clk),
        .rst     (rst),
        .tx_act  (tx_act),
        .sqe_en  (sqe_en),
        .link_ok (link_ok),
        .jab     (jab),
        .burst   (sqe_burst)
    );

    ci_jabber #(
        .LIMIT_CYC (JAB_LIMIT_CYC),
        .UNJAB_CYC (UNJAB_IDLE_CYC)
    ) u_jab (
        .clk    (clk),
        .rst    (rst),
        .tx_act (tx_act),
        .jab    (jab)
    );

    assign src.col    = col_q;
    assign src.sqe    = sqe_burst;
    assign src.jab    = jab;
    assign col_osc_en = |src;

    ci_square_osc #(
        .HALF_CYC (OSC_HALF_CYC)
    ) u_osc (
        .clk    (clk),
        .rst    (rst),
        .en     (col_osc_en),
        .wave_p (col_wave_p),
        .wave_n (col_wave_n)
    );

    assign led_evt[LED_TX]  = tx_act;
    assign led_evt[LED_RX]  = rx_act;
    assign led_evt[LED_COL] = col_q;

    for (genvar g = 0; g < LED_COUNT; g++) begin : g_led
        ci_led_stretch #(
            .ON_CYC (LED_ON_CYC)
        ) u_led (
            .clk      (clk),
            .rst      (rst),
            .event_in (led_evt[g]),
            .led_n    (led_n_vec[g])
        );
    end

    assign led_tx_n  = led_n_vec[LED_TX];
    assign led_rx_n  = led_n_vec[LED_RX];
    assign led_col_n = led_n_vec[LED_COL];
    assign tx_enable = ~jab;
    assign led_jab_n = ~jab;

    // R2
    lb_off_no_col_chk: assert property (@(posedge clk) disable iff (rst)
        lb_off |=> !src.col);

    // R1
    col_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_act || !rx_act) |=> !src.col);

    // R8
    jab_osc_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |-> col_osc_en);

endmodule

// File: tb/test_ci_collision_ctrl.sv
module test_ci_collision_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 2;
    localparam int SQD   = 40;
    localparam int SQL   = 40;
    localparam int JABL  = 2000;
    localparam int UNJ   = 4000;
    localparam int LEDON = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_act = 1'b0, rx_act = 1'b0, tx_data = 1'b0, rx_data = 1'b0;
    logic link_ok = 1'b1, lb_off = 1'b0, sqe_en = 1'b0;
    logic col_osc_en, col_wave_p, col_wave_n, di_data, tx_enable;
    logic led_tx_n, led_rx_n, led_col_n, led_jab_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ci_collision_ctrl #(
        .OSC_HALF_CYC   (HALF),
        .SQE_DELAY_CYC  (SQD),
        .SQE_LEN_CYC    (SQL),
        .JAB_LIMIT_CYC  (JABL),
        .UNJAB_IDLE_CYC (UNJ),
        .LED_ON_CYC     (LEDON)
    ) i_ci_collision_ctrl (
        .clk (clk), .rst (rst),
        .tx_act (tx_act), .rx_act (rx_act),
        .tx_data (tx_data), .rx_data (rx_data),
        .link_ok (link_ok), .lb_off (lb_off), .sqe_en (sqe_en),
        .col_osc_en (col_osc_en), .col_wave_p (col_wave_p), .col_wave_n (col_wave_n),
        .di_data (di_data), .tx_enable (tx_enable),
        .led_tx_n (led_tx_n), .led_rx_n (led_rx_n),
        .led_col_n (led_col_n), .led_jab_n (led_jab_n)
    );

    // {tx, rx, lb_off, tx_data, rx_data, exp_di, exp_col}
    localparam logic [6:0] VEC [11] = '{
        7'b1_0_0_1_0_1_0,   // R3 transmit alone, DO echoed
        7'b1_0_0_0_1_0_0,   // R3 echo follows tx_data
        7'b1_1_0_1_0_0_1,   // R1 collision, DI carries receive data
        7'b1_1_0_0_1_1_1,   // R1 collision held
        7'b1_1_1_1_0_0_0,   // R2 loopback off, no collision
        7'b0_1_0_1_0_0_0,   // R3 receive alone
        7'b0_1_1_0_1_1_0,   // R2 receive with loopback off
        7'b1_0_1_1_0_0_0,   // R2 transmit with loopback off, no echo
        7'b0_0_0_1_1_1_0,   // R3 idle, DI shows receive data
        7'b1_1_0_1_1_1_1,   // R1 collision again
        7'b1_0_0_0_0_0_0    // R1 receive idle releases collision
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tx_act = 1'b0; rx_act = 1'b0; tx_data = 1'b0; rx_data = 1'b0;
        link_ok = 1'b1; lb_off = 1'b0; sqe_en = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset();
        chk("R11 led_tx_n", led_tx_n, 1'b1);
        chk("R11 led_rx_n", led_rx_n, 1'b1);
        chk("R11 led_col_n", led_col_n, 1'b1);
        chk("R11 led_jab_n", led_jab_n, 1'b1);
        chk("R11 tx_enable", tx_enable, 1'b1);
        chk("R11 col_osc_en", col_osc_en, 1'b0);
        chk("R11 col_wave_p", col_wave_p, 1'b0);
        chk("R11 col_wave_n", col_wave_n, 1'b0);

        // R1 R2 R3 vector table, SQE disabled
        for (int i = 0; i < 11; i++) begin
            {tx_act, rx_act, lb_off, tx_data, rx_data} = VEC[i][6:2];
            #1;
            chk("R3 di_data", di_data, VEC[i][1]);
            tick(1);
            chk("R1 col_osc_en", col_osc_en, VEC[i][0]);
        end

        // R5 SQE timing and R4 waveform
        do_reset();
        sqe_en = 1'b1;
        tx_act = 1'b1;
        tick(5);
        tx_act = 1'b0;
        tick(SQD);
        chk("R5 sqe not yet", col_osc_en, 1'b0);
        chk("R4 idle wave_p", col_wave_p, 1'b0);
        chk("R4 idle wave_n", col_wave_n, 1'b0);
        tick(1);
        chk("R5 sqe start", col_osc_en, 1'b1);
        chk("R4 first wave_p", col_wave_p, 1'b0);
        chk("R4 first wave_n", col_wave_n, 1'b1);
        tick(HALF);
        chk("R4 swapped wave_p", col_wave_p, 1'b1);
        chk("R4 swapped wave_n", col_wave_n, 1'b0);
        tick(HALF);
        chk("R4 back wave_p", col_wave_p, 1'b0);
        tick(SQL - 1 - 2 * HALF);
        chk("R5 sqe last", col_osc_en, 1'b1);
        tick(1);
        chk("R5 sqe end", col_osc_en, 1'b0);
        chk("R4 end wave_p", col_wave_p, 1'b0);
        chk("R4 end wave_n", col_wave_n, 1'b0);

        // R6 SQE suppressed by strap or low light
        do_reset();
        sqe_en = 1'b0;
        tx_act = 1'b1;
        tick(5);
        tx_act = 1'b0;
        tick(SQD + 2);
        chk("R6 sqe_en low", col_osc_en, 1'b0);
        sqe_en = 1'b1;
        link_ok = 1'b0;
        tx_act = 1'b1;
        tick(5);
        tx_act = 1'b0;
        tick(SQD + 2);
        chk("R6 link down", col_osc_en, 1'b0);

        // R7 cancel burst on new transmission
        do_reset();
        sqe_en = 1'b1;
        tx_act = 1'b1;
        tick(5);
        tx_act = 1'b0;
        tick(SQD + 2);
        chk("R7 burst running", col_osc_en, 1'b1);
        tx_act = 1'b1;
        tick(1);
        chk("R7 burst cancelled", col_osc_en, 1'b0);
        tx_act = 1'b0;

        // R8 jabber entry, short transmission first
        do_reset();
        tx_act = 1'b1;
        tick(JABL - 1);
        tx_act = 1'b0;
        tick(1);
        chk("R8 short tx keeps enable", tx_enable, 1'b1);
        sqe_en = 1'b1;
        tx_act = 1'b1;
        tick(JABL - 1);
        chk("R8 before limit", tx_enable, 1'b1);
        tick(1);
        chk("R8 tx_enable off", tx_enable, 1'b0);
        chk("R8 led_jab_n", led_jab_n, 1'b0);
        chk("R8 osc on", col_osc_en, 1'b1);

        // R9 unjab after unbroken idle
        tx_act = 1'b0;
        tick(10);
        chk("R9 still jabbering", tx_enable, 1'b0);
        tx_act = 1'b1;
        tick(1);
        tx_act = 1'b0;
        tick(UNJ - 1);
        chk("R9 idle restarted", tx_enable, 1'b0);
        tick(1);
        chk("R9 tx_enable back", tx_enable, 1'b1);
        chk("R9 led_jab_n off", led_jab_n, 1'b1);
        chk("R9 osc off", col_osc_en, 1'b0);
        tick(SQD + 5);
        chk("R9 no sqe after jabber", col_osc_en, 1'b0);

        // R10 LED stretch and retrigger
        do_reset();
        rx_act = 1'b1;
        tick(1);
        rx_act = 1'b0;
        chk("R10 rx led lit", led_rx_n, 1'b0);
        tick(LEDON - 1);
        chk("R10 rx led last", led_rx_n, 1'b0);
        tick(1);
        chk("R10 rx led off", led_rx_n, 1'b1);
        tx_act = 1'b1;
        tick(1);
        tx_act = 1'b0;
        tick(100);
        tx_act = 1'b1;
        tick(1);
        tx_act = 1'b0;
        tick(LEDON - 1);
        chk("R10 tx led retriggered", led_tx_n, 1'b0);
        tick(1);
        chk("R10 tx led off", led_tx_n, 1'b1);
        tx_act = 1'b1;
        rx_act = 1'b1;
        tick(1);
        tx_act = 1'b0;
        rx_act = 1'b0;
        tick(1);
        chk("R10 col led lit", led_col_n, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule